// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two wires of a low-speed USB link into a stream of received bytes. It runs from a system clock that is a fixed multiple (eight by default) of the line bit rate. It waits on an idle line for the first J-to-K transition. It then watches the sync field until it sees two K bit periods in a row, and from that point decodes packet data. Every transition on D- pulls the bit-sampling phase back to that edge, so the sample point stays near the middle of each bit even when the transmitter's clock is off by about one percent.

Data is NRZI-decoded, stuffed bits are removed, and bits are packed into bytes least significant bit first. Each completed byte appears on `byte_data` with a one-clock `byte_valid` strobe. A packet ends when the line shows SE0 at two consecutive bit samples. Any bits received since the last full byte are then handed out as a final short byte, and `eop` pulses. A per-packet byte budget guards the buffer that sits downstream. A start that never completes its sync is dropped after a bounded number of bit samples. Protocol checks on the content (PID, CRC, address) belong to later stages.

Top module: `usb_lsrx`

## Requirements
- R1: During and right after synchronous reset, `byte_valid`, `eop`, `overflow` and `packet_active` are all 0.
- R2: After a falling D- edge on an idle line, `packet_active` stays 0 until two consecutive bit samples show the K state (D+ = 1, D- = 0). It then rises, and data decoding starts with the next bit.
- R3: A bit whose D- level equals the previous bit's level decodes as 1; a level change decodes as 0. The first decoded bit of a byte goes to `byte_data[0]`. Every 8 kept bits give one `byte_valid` pulse that lasts exactly one clock.
- R4: After six consecutive decoded 1s, the next bit is discarded and not packed into a byte. The run of 1s keeps counting across byte boundaries and restarts at zero when data decoding starts.
- R5: Each D- transition realigns the sampling phase, so packets whose bit period is stretched or shrunk by one clock every 12 bits (at 8 clocks per bit) still decode without error.
- R6: SE0 (D+ = 0, D- = 0) at two consecutive bit samples produces a one-clock `eop` pulse in the same cycle that `packet_active` falls. The receiver then waits for the next start edge.
- R7: If 1 to 7 bits were kept since the last full byte when SE0 ends the packet, they are output as a byte in bit positions counted from 0, with zeros above. Its `byte_valid` is in the same cycle as `eop`.
- R8: SE0 at a single bit sample, followed by a J or K, has no effect. No bit is decoded for it, no `eop` is produced, and the next bit is compared with the level before the SE0.
- R9: Each packet may output at most BUF_BYTES bytes, counting a final short byte. The first byte beyond that budget sets `overflow`, and neither it nor any later byte of the packet is output. `eop` still pulses at the end. `overflow` stays 1 until the next packet's sync completes.
- R10: If two consecutive K samples are not found within SYNC_LIMIT bit samples after the start edge, the attempt is dropped. No `packet_active`, `byte_valid` or `eop` is produced, and the next packet is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OVS times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| dp | input | 1 | D+ line, asynchronous |
| dm | input | 1 | D- line, asynchronous |
| byte_data | output | 8 | Received byte, LSB first on the wire |
| byte_valid | output | 1 | One-clock strobe for `byte_data` |
| eop | output | 1 | One-clock end-of-packet strobe |
| overflow | output | 1 | Byte budget exceeded in the current or last packet |
| packet_active | output | 1 | High while packet data is being decoded |

## Verification
Two things can happen at the same sample: the second SE0 sample closes the packet and also flushes the short last byte. The bench provokes this by ending packets a few bits after a byte boundary. It then requires that the one `byte_valid` strobe and the `eop` strobe are seen on the same clock. A second case: the budget check lands on that same short byte when a packet holds exactly BUF_BYTES full bytes plus spare bits. Here the bench expects `eop` with no strobe at all and `overflow` set. Every single-byte value is also swept, and long packets are sent with a drifting bit period.

// File: rtl/usb_lsrx_pkg.sv
package usb_lsrx_pkg;

    // line state, encoded as {dp, dm}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SYNC,
        RX_DATA
    } rx_state_t;

    localparam int STUFF_RUN = 6;
    localparam int BYTE_BITS = 8;

    function automatic line_t classify(input logic dp, input logic dm);
        return line_t'({dp, dm});
    endfunction

endpackage

// File: rtl/usb_lsrx_sync.sv
module usb_lsrx_sync #(
    parameter int STAGES = 2,
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= din;
                else stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/usb_lsrx_timer.sv
module usb_lsrx_timer #(
    parameter int OVS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic dm_in,
    output logic edge_seen,
    output logic smp
);
    localparam int PW   = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int HALF = OVS / 2;

    logic [PW-1:0] ph;
    logic          dm_prev;

    assign edge_seen = (dm_in != dm_prev);
    assign smp       = (ph == PW'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= '0;
            dm_prev <= 1'b1;
        end else begin
            dm_prev <= dm_in;
            if (edge_seen)                ph <= PW'(1);
            else if (ph == PW'(OVS - 1))  ph <= '0;
            else                          ph <= ph + PW'(1);
        end
    end

    AST_PHASE_REALIGN: assert property (@(posedge clk) disable iff (rst)
        $past(edge_seen && !rst) |-> (ph == PW'(1)));          // R5
    AST_SAMPLE_NOT_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        $past(edge_seen && !rst) |-> !smp);                    // R5
endmodule

// File: rtl/usb_lsrx_deframe.sv
module usb_lsrx_deframe
    import usb_lsrx_pkg::*;
#(
    parameter int BUF_BYTES  = 8,
    parameter int SYNC_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp,
    input  logic       edge_seen,
    input  line_t      ln,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       eop,
    output logic       overflow,
    output logic       packet_active
);
    localparam int TW = $clog2(SYNC_LIMIT + 1);
    localparam int CW = $clog2(BUF_BYTES + 1);
    localparam logic [TW-1:0] TLIM = TW'(SYNC_LIMIT - 1);

    rx_state_t     st;
    logic          kseen;
    logic [TW-1:0] tcnt;
    logic          last_dm;
    logic [2:0]    ones;
    logic [2:0]    bitcnt;
    logic [7:0]    sr;
    logic          se0_prev;
    logic [CW-1:0] left;

    logic       bit_one, is_stuff, take_full, take_part, push;
    logic [7:0] nxt, push_val;

    always_comb begin
        bit_one   = (ln[0] == last_dm);
        is_stuff  = (ones == 3'(STUFF_RUN));
        nxt       = sr | (8'(bit_one) << bitcnt);
        take_full = (st == RX_DATA) && smp && (ln != LN_SE0) && !is_stuff
                    && (bitcnt == 3'(BYTE_BITS - 1));
        take_part = (st == RX_DATA) && smp && (ln == LN_SE0) && se0_prev
                    && (bitcnt != 3'd0);
        push      = (take_full || take_part) && !overflow;
        push_val  = take_full ? nxt : sr;
    end

    assign packet_active = (st == RX_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= RX_IDLE;
            kseen      <= 1'b0;
            tcnt       <= '0;
            last_dm    <= 1'b1;
            ones       <= '0;
            bitcnt     <= '0;
            sr         <= '0;
            se0_prev   <= 1'b0;
            left       <= '0;
            overflow   <= 1'b0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            eop        <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            eop        <= 1'b0;
            if (push) begin
                if (left == '0) overflow <= 1'b1;
                else begin
                    byte_data  <= push_val;
                    byte_valid <= 1'b1;
                    left       <= left - CW'(1);
                end
            end
            case (st)
                RX_IDLE: begin
                    if (edge_seen && ln == LN_K) begin
                        st    <= RX_SYNC;
                        kseen <= 1'b0;
                        tcnt  <= '0;
                    end
                end
                RX_SYNC: begin
                    if (smp) begin
                        if (ln == LN_K && kseen) begin
                            st       <= RX_DATA;
                            last_dm  <= 1'b0;
                            ones     <= '0;
                            bitcnt   <= '0;
                            sr       <= '0;
                            se0_prev <= 1'b0;
                            left     <= CW'(BUF_BYTES);
                            overflow <= 1'b0;
                        end else begin
                            kseen <= (ln == LN_K);
                            tcnt  <= tcnt + TW'(1);
                            if (tcnt == TLIM) st <= RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    if (smp) begin
                        if (ln == LN_SE0) begin
                            if (se0_prev) begin
                                eop <= 1'b1;
                                st  <= RX_IDLE;
                            end
                            se0_prev <= 1'b1;
                        end else begin
                            se0_prev <= 1'b0;
                            last_dm  <= ln[0];
                            if (is_stuff) begin
                                ones <= '0;
                            end else begin
                                ones <= bit_one ? ones + 3'd1 : 3'd0;
                                if (bitcnt == 3'(BYTE_BITS - 1)) begin
                                    bitcnt <= '0;
                                    sr     <= '0;
                                end else begin
                                    bitcnt <= bitcnt + 3'd1;
                                    sr     <= nxt;
                                end
                            end
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);                               // R3
    AST_EOP_ENDS_PACKET: assert property (@(posedge clk) disable iff (rst)
        eop |-> (!packet_active && $past(packet_active)));         // R6
    AST_EOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eop |=> !eop);                                             // R6
    AST_NO_VALID_WHEN_OVF: assert property (@(posedge clk) disable iff (rst)
        overflow |-> !byte_valid);                                 // R9
    AST_STUFF_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        ones <= 3'(STUFF_RUN));                                    // R4
    AST_SYNC_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == RX_SYNC) |-> (tcnt <= TLIM));                       // R10
endmodule

// File: rtl/usb_lsrx.sv
module usb_lsrx
    import usb_lsrx_pkg::*;
#(
    parameter int OVS        = 8,
    parameter int BUF_BYTES  = 8,
    parameter int SYNC_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dp,
    input  logic       dm,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       eop,
    output logic       overflow,
    output logic       packet_active
);
    logic [1:0] pins_s;
    logic       edge_seen, smp;
    line_t      ln;

    usb_lsrx_sync #(.STAGES(2), .W(2), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst(rst), .din({dp, dm}), .dout(pins_s)
    );

    assign ln = classify(pins_s[1], pins_s[0]);

    usb_lsrx_timer #(.OVS(OVS)) u_timer (
        .clk(clk), .rst(rst), .dm_in(pins_s[0]),
        .edge_seen(edge_seen), .smp(smp)
    );

    usb_lsrx_deframe #(.BUF_BYTES(BUF_BYTES), .SYNC_LIMIT(SYNC_LIMIT)) u_deframe (
        .clk(clk), .rst(rst), .smp(smp), .edge_seen(edge_seen), .ln(ln),
        .byte_data(byte_data), .byte_valid(byte_valid), .eop(eop),
        .overflow(overflow), .packet_active(packet_active)
    );
endmodule

// File: tb/tb_usb_lsrx.sv
`timescale 1ns/1ps
module tb_usb_lsrx;
    localparam int OVS = 8;
    localparam int BUF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dp = 1'b0;
    logic dm = 1'b1;
    logic [7:0] byte_data;
    logic byte_valid, eop, overflow, packet_active;

    always #2.5 clk = ~clk;

    usb_lsrx #(.OVS(OVS), .BUF_BYTES(BUF), .SYNC_LIMIT(16)) dut (
        .clk(clk), .rst(rst), .dp(dp), .dm(dm),
        .byte_data(byte_data), .byte_valid(byte_valid), .eop(eop),
        .overflow(overflow), .packet_active(packet_active)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] pay [16];
    logic [7:0] rx  [16];
    int rx_n = 0, eop_n = 0, both_n = 0, act_rises = 0;
    logic act_d = 1'b0;
    logic lvl = 1'b1;
    int ones = 0;
    int drift = 0;
    int bitn = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (rx_n < 16) rx[rx_n] = byte_data;
                rx_n++;
            end
            if (eop) eop_n++;
            if (eop && byte_valid) both_n++;
            if (packet_active && !act_d) act_rises++;
            act_d = packet_active;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic p, input logic m);
        int len;
        len = OVS;
        if (drift != 0) begin
            bitn++;
            if (bitn % 12 == 0) len = OVS + drift;
        end
        dp = p;
        dm = m;
        repeat (len) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        if (!b) lvl = ~lvl;
        put(~lvl, lvl);
        if (b) ones++; else ones = 0;
        if (ones == 6) begin
            lvl = ~lvl;
            put(~lvl, lvl);
            ones = 0;
        end
    endtask

    task automatic send_pkt(input int nb, input int xb, input bit mid_se0);
        rx_n = 0; eop_n = 0; both_n = 0; act_rises = 0;
        repeat (3) put(1'b0, 1'b1);
        put(1'b1, 1'b0); put(1'b0, 1'b1); put(1'b1, 1'b0); put(1'b0, 1'b1);
        put(1'b1, 1'b0); put(1'b0, 1'b1); put(1'b1, 1'b0);
        chk(!packet_active, "R2", "active before second K", int'(packet_active), 0);
        put(1'b1, 1'b0);
        lvl = 1'b0;
        ones = 0;
        for (int i = 0; i < nb; i++) begin
            for (int j = 0; j < 8; j++) send_bit(pay[i][j]);
            if (mid_se0 && i == 0) put(1'b0, 1'b0);
        end
        for (int j = 0; j < xb; j++) send_bit(pay[nb][j]);
        put(1'b0, 1'b0);
        put(1'b0, 1'b0);
        repeat (4) put(1'b0, 1'b1);
        lvl = 1'b1;
    endtask

    task automatic check_pkt(input int nb, input int xb, input string req);
        int tot, emit;
        bit ovf_exp;
        logic [7:0] e;
        tot = nb + ((xb > 0) ? 1 : 0);
        ovf_exp = (tot > BUF);
        emit = ovf_exp ? BUF : tot;
        chk(rx_n == emit, req, "byte count", rx_n, emit);
        for (int i = 0; i < emit && i < rx_n; i++) begin
            e = (i < nb) ? pay[i] : (pay[nb] & 8'((1 << xb) - 1));
            chk(rx[i] == e, req, $sformatf("byte %0d", i), int'(rx[i]), int'(e));
        end
        chk(eop_n == 1, "R6", "eop pulses", eop_n, 1);
        chk(act_rises == 1, "R2", "packet_active rises", act_rises, 1);
        chk(both_n == ((xb > 0 && !ovf_exp) ? 1 : 0), "R7", "valid with eop",
            both_n, (xb > 0 && !ovf_exp) ? 1 : 0);
        chk(overflow == ovf_exp, "R9", "overflow level", int'(overflow), int'(ovf_exp));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(!byte_valid && !eop && !overflow && !packet_active, "R1", "reset outputs",
            {byte_valid, eop, overflow, packet_active}, 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!byte_valid && !eop && !overflow && !packet_active, "R1", "after reset",
            {byte_valid, eop, overflow, packet_active}, 0);

        // R3: every single-byte value
        for (int b = 0; b < 256; b++) begin
            pay[0] = 8'(b);
            send_pkt(1, 0, 1'b0);
            chk(rx_n == 1 && rx[0] == 8'(b) && eop_n == 1 && act_rises == 1, "R3",
                "single byte sweep", int'(rx[0]), b);
        end

        // R4: long runs of ones, stuffing across byte edges
        pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'hFF; pay[3] = 8'h7F;
        send_pkt(4, 0, 1'b0);
        check_pkt(4, 0, "R4");
        pay[0] = 8'hFC; pay[1] = 8'h3F; pay[2] = 8'h80; pay[3] = 8'h01;
        send_pkt(4, 0, 1'b0);
        check_pkt(4, 0, "R4");

        // R7: short last byte flushed together with eop
        pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'hFD;
        send_pkt(2, 3, 1'b0);
        check_pkt(2, 3, "R7");
        pay[0] = 8'h12; pay[1] = 8'hFF;
        send_pkt(1, 7, 1'b0);
        check_pkt(1, 7, "R7");

        // R8: one-sample SE0 in mid packet is ignored
        pay[0] = 8'h5A; pay[1] = 8'hC3;
        send_pkt(2, 0, 1'b1);
        check_pkt(2, 0, "R8");

        // R9: budget exceeded by full bytes, then by a short byte
        for (int i = 0; i < 12; i++) pay[i] = 8'(i * 37 + 5);
        send_pkt(10, 0, 1'b0);
        check_pkt(10, 0, "R9");
        send_pkt(8, 2, 1'b0);
        check_pkt(8, 2, "R9");
        pay[0] = 8'h99;
        send_pkt(1, 0, 1'b0);
        check_pkt(1, 0, "R9");

        // R5: bit period drifting both ways
        for (int i = 0; i < 8; i++) pay[i] = 8'(i * 29 + 11);
        drift = 1; bitn = 0;
        send_pkt(8, 0, 1'b0);
        check_pkt(8, 0, "R5");
        drift = -1; bitn = 0;
        send_pkt(8, 0, 1'b0);
        check_pkt(8, 0, "R5");
        drift = 0;

        // R10: lone K glitch, sync never completes
        rx_n = 0; eop_n = 0; both_n = 0; act_rises = 0;
        put(1'b1, 1'b0);
        repeat (20) put(1'b0, 1'b1);
        chk(rx_n == 0 && eop_n == 0 && act_rises == 0, "R10", "abandoned start",
            rx_n + eop_n + act_rises, 0);
        pay[0] = 8'h6E;
        send_pkt(1, 0, 1'b0);
        check_pkt(1, 0, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule